// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter with Chunk Retransmission

This block is the sending half of a keyboard or mouse on a two-wire PS/2 link. A producer pushes bytes into a 16-entry queue and marks the final byte of each chunk. A chunk is a group of bytes that must reach the host as a unit, such as a multi-byte break code or a movement packet. The block generates the bus clock itself and drives both lines open-drain: an output enable pulls a line low, and releasing it lets the pull-up raise the line. Each byte goes out as an 11-bit frame.

Before each frame the block waits for the clock line to stay high for a minimum idle time. While the clock is released it reads the line back, so it can see the host holding the clock low. If the host does this before the eleventh falling edge of a frame, the frame is abandoned and the whole chunk is sent again from its first byte. Queue entries are freed only when the last byte of a chunk has been fully clocked out. While the queue is full, new bytes are dropped.

All timing is counted in system-clock cycles, derived from the `CLK_HZ` parameter and microsecond parameters. The data line changes about half-way through each clock-high phase.

Top module: `ps2_dev_tx`

## Requirements
- R1: During and after reset, with no queued bytes, both output enables are 0, so the clock and data lines are released.
- R2: A frame starts only after the clock line has been sampled high without a break for IDLE_US microseconds. A low sample during the wait restarts the count. The first falling edge of a frame comes IDLE_US+HALF_US (plus a few cycles of synchroniser delay) after the host releases the clock.
- R3: Each byte is sent as 11 bits, each sampled by the host on a clock falling edge. The order is: bit 0 is the start bit (0), bits 1 to 8 carry the data LSB first, bit 9 is odd parity (the data ones plus the parity bit give an odd count), and bit 10 is the stop bit (1).
- R4: Inside a frame, every clock-low phase and every clock-high phase between pulses lasts HALF_US microseconds.
- R5: The data line changes only while the clock is high, HALF_US/2 microseconds (within a cycle or two) after the rising edge.
- R6: If the clock line reads low during a clock-high phase before the eleventh falling edge, the frame is aborted. After the idle wait, the chunk is resent starting from its first byte.
- R7: A host inhibit that begins after the eleventh falling edge of a byte does not cause that byte to be resent.
- R8: The queue holds 16 bytes. A byte pushed while it is full is dropped and never sent.
- R9: Bytes of a chunk keep their queue slots until the final byte of the chunk completes. A byte pushed while a full chunk is still in flight is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Push strobe for one byte |
| in_byte | input | 8 | Byte to queue |
| in_last | input | 1 | Pushed byte ends its chunk |
| ps2_clk_i | input | 1 | Read-back of the PS/2 clock line |
| ps2_clk_oe | output | 1 | 1 pulls the PS/2 clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the PS/2 data line low |

## Verification
Internal errors show up quickly at the line outputs. A wrong bit index or shift shows as a bad start bit, stop bit or parity within one 11-bit frame. A mistimed phase counter shows as a clock phase of the wrong length on the very next edge. A queue pointer that is rewound or committed at the wrong moment is slower to show. It appears only after the host's inhibit is released, when a chunk is resent from the wrong byte, or when a byte pushed into a supposedly full queue is sent frames later. The bench therefore compares complete received byte sequences after each inhibit scenario.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int SYNC_LAT   = 3;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_HIGH,
        ST_LOW
    } tx_state_e;
endpackage

// File: rtl/ps2_tx_queue.sv
// Circular byte queue with a speculative read pointer for chunk replay.
// DEPTH must be a power of two.
module ps2_tx_queue #(
    parameter  int DEPTH = 16,
    parameter  int W     = 9,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_word,
    input  logic          advance,
    input  logic          rewind,
    input  logic          commit,
    output logic          avail,
    output logic [W-1:0]  rd_word,
    output logic [AW:0]   level
);
    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] head;
        logic [AW:0] rd;
    } q_t;

    q_t            q_q, q_d;
    logic [W-1:0]  mem [DEPTH];
    logic          full;
    logic          accept;

    assign level   = q_q.wr - q_q.head;
    assign full    = (level == (AW+1)'(DEPTH));
    assign accept  = push && !full;
    assign avail   = (q_q.rd != q_q.wr);
    assign rd_word = mem[q_q.rd[AW-1:0]];

    always_comb begin
        q_d = q_q;
        if (accept)       q_d.wr = q_q.wr + 1'b1;
        if (rewind)       q_d.rd = q_q.head;
        else if (advance) q_d.rd = q_q.rd + 1'b1;
        if (commit)       q_d.head = q_d.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[q_q.wr[AW-1:0]] <= push_word;
    end
endmodule

// File: rtl/ps2_tx_frame.sv
// Sends one 11-bit frame: idle wait, then HIGH/LOW phases per bit.
module ps2_tx_frame
    import ps2_tx_pkg::*;
#(
    parameter int HALF = 40,
    parameter int SETP = 20,
    parameter int IDLE = 50,
    parameter int CW   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_hi,
    input  logic       req,
    input  logic [7:0] data,
    output logic       done,
    output logic       abort,
    output logic       clk_oe,
    output logic       dat_oe
);
    typedef struct packed {
        tx_state_e                 state;
        logic [CW-1:0]             cnt;
        logic [3:0]                bitn;
        logic [FRAME_BITS-1:0]     shreg;
        logic                      clk_oe;
        logic                      dat_oe;
        logic                      done;
        logic                      abort;
    } fr_t;

    fr_t f_q, f_d;

    always_comb begin
        f_d       = f_q;
        f_d.done  = 1'b0;
        f_d.abort = 1'b0;
        unique case (f_q.state)
            ST_WAIT: begin
                f_d.clk_oe = 1'b0;
                f_d.dat_oe = 1'b0;
                if (!line_hi) begin
                    f_d.cnt = '0;
                end else if (f_q.cnt != CW'(IDLE)) begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end else if (req) begin
                    f_d.shreg = {1'b1, ~^data, data, 1'b0};
                    f_d.state = ST_HIGH;
                    f_d.cnt   = '0;
                    f_d.bitn  = '0;
                end
            end
            ST_HIGH: begin
                if (f_q.cnt >= CW'(SYNC_LAT) && !line_hi) begin
                    f_d.state  = ST_WAIT;
                    f_d.cnt    = '0;
                    f_d.dat_oe = 1'b0;
                    f_d.abort  = 1'b1;
                end else begin
                    if (f_q.cnt == CW'(SETP)) f_d.dat_oe = ~f_q.shreg[0];
                    if (f_q.cnt == CW'(HALF-1)) begin
                        f_d.clk_oe = 1'b1;
                        f_d.state  = ST_LOW;
                        f_d.cnt    = '0;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (f_q.cnt == CW'(HALF-1)) begin
                    f_d.clk_oe = 1'b0;
                    f_d.cnt    = '0;
                    if (f_q.bitn == 4'(FRAME_BITS-1)) begin
                        f_d.state  = ST_WAIT;
                        f_d.dat_oe = 1'b0;
                        f_d.done   = 1'b1;
                    end else begin
                        f_d.bitn  = f_q.bitn + 1'b1;
                        f_d.shreg = f_q.shreg >> 1;
                        f_d.state = ST_HIGH;
                    end
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            default: f_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.state <= ST_WAIT;
        end else begin
            f_q <= f_d;
        end
    end

    assign done   = f_q.done;
    assign abort  = f_q.abort;
    assign clk_oe = f_q.clk_oe;
    assign dat_oe = f_q.dat_oe;
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int HALF_US = 40,
    parameter int IDLE_US = 50,
    parameter int DEPTH   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_last,
    input  logic       ps2_clk_i,
    output logic       ps2_clk_oe,
    output logic       ps2_dat_oe
);
    localparam int CPU  = CLK_HZ / 1_000_000;
    localparam int HALF = HALF_US * CPU;
    localparam int SETP = HALF / 2;
    localparam int IDLE = IDLE_US * CPU;
    localparam int LIM  = (IDLE > HALF) ? IDLE : HALF;
    localparam int CW   = $clog2(LIM + 1);
    localparam int AW   = $clog2(DEPTH);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t        sy_q, sy_d;
    logic [8:0]   q_word;
    logic         q_avail;
    logic [AW:0]  q_level;
    logic         fr_done, fr_abort;

    always_comb begin
        sy_d.s1 = ps2_clk_i;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    ps2_tx_queue #(.DEPTH(DEPTH), .W(9)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_word ({in_last, in_byte}),
        .advance   (fr_done),
        .rewind    (fr_abort),
        .commit    (fr_done && q_word[8]),
        .avail     (q_avail),
        .rd_word   (q_word),
        .level     (q_level)
    );

    ps2_tx_frame #(.HALF(HALF), .SETP(SETP), .IDLE(IDLE), .CW(CW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_hi (sy_q.s2),
        .req     (q_avail),
        .data    (q_word[7:0]),
        .done    (fr_done),
        .abort   (fr_abort),
        .clk_oe  (ps2_clk_oe),
        .dat_oe  (ps2_dat_oe)
    );
endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
    parameter int HALF  = 40,
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_oe,
    input logic          dat_oe,
    input logic          clk_line,
    input logic [LW-1:0] level
);
    logic [15:0] low_run, high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run  <= '0;
            high_run <= '0;
        end else begin
            low_run  <= clk_oe ? ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1) : '0;
            high_run <= (!clk_oe && clk_line)
                        ? ((high_run == 16'hFFFF) ? high_run : high_run + 1'b1) : '0;
        end
    end

    assert_released_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!clk_oe && !dat_oe));

    assert_low_phase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 16'(HALF));

    assert_high_before_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_oe) |-> (high_run >= 16'(HALF - 2)));

    assert_data_still_when_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe && $past(clk_oe)) |-> $stable(dat_oe));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.HALF(HALF), .DEPTH(DEPTH), .LW(AW + 1)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_oe   (ps2_clk_oe),
    .dat_oe   (ps2_dat_oe),
    .clk_line (ps2_clk_i),
    .level    (q_level)
);

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;
    // CLK_HZ is scaled to 1 MHz so one cycle counts as one microsecond.
    localparam int HALF = 40;
    localparam int SETP = 20;
    localparam int IDLE = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_last = 1'b0;
    logic       host_inh = 1'b0;
    logic       clk_oe, dat_oe;
    wire        clk_line = !clk_oe && !host_inh;
    wire        dat_line = !dat_oe;

    always #5 clk = ~clk;

    ps2_dev_tx #(.CLK_HZ(1_000_000)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_last    (in_last),
        .ps2_clk_i  (clk_line),
        .ps2_clk_oe (clk_oe),
        .ps2_dat_oe (dat_oe)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // host-side receiver model
    int         cyc = 0;
    int         rx_n = 0;
    logic [7:0] rx_buf [0:63];
    int         rx_ferr = 0, phase_bad = 0, dchg_bad = 0, setp_bad = 0;
    int         nb = 0, run = 0, first_fall = 0;
    bit         meas = 0, prev_clk = 1, prev_dat = 1;
    logic [10:0] bits;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n || host_inh) begin
            nb   = 0;
            meas = 0;
        end else begin
            if (prev_clk && !clk_line) begin
                if (meas && nb > 0 && (run < HALF - 1 || run > HALF + 1)) phase_bad++;
                if (nb == 0) first_fall = cyc;
                bits[nb] = dat_line;
                nb++;
                meas = 1;
                if (nb == 11) begin
                    if (bits[0] != 1'b0 || bits[10] != 1'b1 || ^bits[9:1] != 1'b1) rx_ferr++;
                    if (rx_n < 64) rx_buf[rx_n] = bits[8:1];
                    rx_n++;
                    nb = 0;
                end
            end
            if (!prev_clk && clk_line && meas && (run < HALF - 1 || run > HALF + 1)) phase_bad++;
            if (dat_line != prev_dat) begin
                if (!clk_line) dchg_bad++;
                else if (meas && nb > 0 && (run < SETP - 1 || run > SETP + 2)) setp_bad++;
            end
        end
        if (clk_line == prev_clk) run++;
        else run = 1;
        prev_clk = clk_line;
        prev_dat = dat_line;
    end

    task automatic push(input logic [7:0] b, input logic last);
        @(posedge clk); #1;
        in_valid = 1'b1; in_byte = b; in_last = last;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_rx(input int n, input int lim);
        for (int i = 0; i < lim && rx_n < n; i++) @(negedge clk);
    endtask

    task automatic inhibit(input int len);
        @(posedge clk); #1 host_inh = 1'b1;
        repeat (len) @(posedge clk);
        #1 host_inh = 1'b0;
    endtask

    task automatic test_reset();
        repeat (200) @(negedge clk);
        check(clk_oe == 1'b0, "R1", "clock enable idle", clk_oe, 0);
        check(dat_oe == 1'b0, "R1", "data enable idle", dat_oe, 0);
        check(rx_n == 0, "R1", "no frames when empty", rx_n, 0);
    endtask

    task automatic test_patterns();
        logic [7:0] pat [5] = '{8'h15, 8'h00, 8'hFF, 8'hA5, 8'h80};
        for (int i = 0; i < 5; i++) begin
            int base = rx_n;
            push(pat[i], 1'b1);
            wait_rx(base + 1, 3000);
            check(rx_n == base + 1 && rx_buf[base] == pat[i], "R3", "byte value",
                  rx_buf[base], pat[i]);
        end
        check(rx_ferr == 0, "R3", "start/parity/stop errors", rx_ferr, 0);
        check(phase_bad == 0, "R4", "clock phase length errors", phase_bad, 0);
        check(dchg_bad == 0, "R5", "data changes while clock low", dchg_bad, 0);
        check(setp_bad == 0, "R5", "data change off mid-high point", setp_bad, 0);
    endtask

    task automatic test_idle_wait();
        int base = rx_n;
        int t1;
        host_inh = 1'b1;
        push(8'h5A, 1'b1);
        repeat (150) @(negedge clk);
        check(rx_n == base && clk_oe == 1'b0, "R2", "no clocking while inhibited", rx_n, base);
        @(posedge clk); #1 host_inh = 1'b0;
        repeat (30) @(posedge clk);
        inhibit(5);
        t1 = cyc;
        wait_rx(base + 1, 3000);
        check(first_fall - t1 >= IDLE + HALF && first_fall - t1 <= IDLE + HALF + 8,
              "R2", "delay release to first fall", first_fall - t1, IDLE + HALF + 3);
        check(rx_buf[base] == 8'h5A, "R2", "byte after idle wait", rx_buf[base], 8'h5A);
    endtask

    task automatic test_abort();
        int base = rx_n;
        push(8'hF0, 1'b0);
        push(8'h1C, 1'b1);
        for (int i = 0; i < 5000 && !(rx_n == base + 1 && nb >= 4); i++) @(negedge clk);
        inhibit(100);
        wait_rx(base + 3, 6000);
        check(rx_buf[base] == 8'hF0, "R6", "first byte before abort", rx_buf[base], 8'hF0);
        check(rx_buf[base+1] == 8'hF0, "R6", "chunk resent from first byte", rx_buf[base+1], 8'hF0);
        check(rx_buf[base+2] == 8'h1C, "R6", "second byte after resend", rx_buf[base+2], 8'h1C);
        repeat (2000) @(negedge clk);
        check(rx_n == base + 3, "R6", "frame count after abort", rx_n, base + 3);
    endtask

    task automatic test_late_inhibit();
        int base = rx_n;
        push(8'h33, 1'b1);
        wait_rx(base + 1, 3000);
        inhibit(100);
        repeat (2500) @(negedge clk);
        check(rx_n == base + 1, "R7", "no resend after last edge", rx_n, base + 1);
        check(rx_buf[base] == 8'h33, "R7", "byte value", rx_buf[base], 8'h33);
    endtask

    task automatic test_full();
        int base = rx_n;
        host_inh = 1'b1;
        for (int i = 1; i <= 16; i++) push(8'(i), i == 16);
        push(8'hEE, 1'b1);
        push(8'hEE, 1'b1);
        repeat (20) @(posedge clk);
        #1 host_inh = 1'b0;
        wait_rx(base + 1, 3000);
        push(8'hDD, 1'b1);
        wait_rx(base + 16, 20000);
        repeat (3000) @(negedge clk);
        check(rx_n == base + 16, "R8", "dropped bytes when full", rx_n, base + 16);
        for (int i = 0; i < 16; i++)
            check(rx_buf[base+i] == 8'(i + 1), "R8", "queued byte order", rx_buf[base+i], i + 1);
        push(8'h77, 1'b1);
        wait_rx(base + 17, 3000);
        check(rx_n == base + 17 && rx_buf[base+16] == 8'h77, "R9",
              "space freed only after chunk end", rx_buf[base+16], 8'h77);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        test_reset();
        test_patterns();
        test_idle_wait();
        test_abort();
        test_late_inhibit();
        test_full();
        check(rx_ferr == 0, "R3", "frame errors overall", rx_ferr, 0);
        check(phase_bad == 0, "R4", "phase errors overall", phase_bad, 0);
        finish_run();
    end
endmodule